// File: doc/BRIEF.md
# Segmented Wide-Register Loader

This block sits between a 16-bit host bus and a set of 64-bit internal words. Each host access is framed by an active-low chip enable. The cycle type is taken from the write and command/data selects when the access opens, and the access takes effect when it closes. Data accesses move one 16-bit slice at a time. A destination counter steps through the slices of the word being written, and a source counter steps through the slices of the word being read. Each counter runs between a programmable first and last slice.

Four targets can be written or read: the comparand, mask one, mask two and an entry of a small local table. The table entry is picked by an address register. A write can be filtered through mask one or mask two. A mask bit of 1 keeps the old destination bit, and a mask bit of 0 lets the bus bit through.

When a write to the comparand or either mask lands on the last slice of the destination range, the block raises a one-cycle compare request for the search logic that follows it. The comparand and mask two can each be rotated by one bit in either direction. Two complete configuration banks can be exchanged with one command. The exchange raises a one-cycle pulse that clears the downstream match state.

Top module: `seg_loader`

## Requirements
- R1: The cycle type is taken from {we_ni, cm_ni} as follows: 00 is a command write, 01 is a data write, 10 is a command read and 11 is a data read. A command word holds its opcode in dq bits 15:12, and a command whose bits 11:8 are not zero is ignored.
- R2: The cycle type is latched on the first clock with ce_ni low, so changing we_ni or cm_ni later in the same access has no effect. Register contents change only at the clock where ce_ni is first seen high again.
- R3: dq_oe_o is high only while ce_ni is low during a read cycle, and dq_o is zero whenever dq_oe_o is low.
- R4: A data write updates the slice given by the destination counter (slice k is bits 16k+15:16k). The counter then moves to the next slice, or back to its first slice after its last slice. Command opcode 1 sets the destination from bits 1:0: 0 is the comparand, 1 is mask one, 2 is mask two and 3 is a table entry.
- R5: Command opcode 3 loads the slice limits and resets both counters to their first slice. The fields are: destination first slice in bits 1:0, destination last slice in bits 3:2, source first slice in bits 5:4 and source last slice in bits 7:6.
- R6: cmp_req_o pulses for exactly one cycle, one clock after the commit of a data write to the comparand or a mask that lands on the destination's last slice. It stays low for table-entry writes and for writes to any other slice.
- R7: Command opcode 1, bits 3:2, selects the write mask: 1 is mask one, 2 is mask two, and 0 or 3 means no mask. A masked bit equal to 1 keeps the old destination bit.
- R8: Command opcode 5 rotates by one bit. Bit 0 picks the comparand (0) or mask two (1), and bit 1 picks left (0) or right (1).
- R9: Command opcode 6 swaps between two banks. Each bank holds its own selects, limits, counters, address and mask one. A swap pulses match_clr_o for one cycle.
- R10: Command opcode 4 resets, in one access, the active bank's limits to 0..3 and its counters to 0.
- R11: A data read returns the source slice given by the source counter and then advances that counter. Command opcode 2 sets the source from bits 1:0, using the same codes as R4. A command read returns the destination counter in bits 1:0, the source counter in bits 3:2 and the active bank in bit 4, and advances no counter.
- R12: Command opcode 7 loads the table address from the low dq bits. Writes and reads of a table entry go to that address.
- R13: After reset, the comparand, both masks and all table entries are zero. Both banks target the comparand, with no write mask and counters at 0 over slices 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Access enable, active low |
| we_ni | input | 1 | Write select, active low |
| cm_ni | input | 1 | Command select, active low |
| dq_i | input | 16 | Bus data in |
| dq_o | output | 16 | Bus data out |
| dq_oe_o | output | 1 | Bus output enable |
| cmp_req_o | output | 1 | Compare request pulse |
| match_clr_o | output | 1 | Match clear pulse on bank swap |
| cmp_word_o | output | 64 | Comparand |
| mask1_o | output | 64 | Mask one of the active bank |
| mask2_o | output | 64 | Mask two |

## Verification
A destination counter that is off by one places the next written slice in the wrong lane of the comparand or mask. The mismatch shows on the 64-bit word outputs one clock after that access closes. The same fault moves the compare request to the wrong access. A wrong source counter or bank bit appears on dq_o during the very next read access, and every command read also exposes both counters directly. A masked merge that drops or inverts the keep rule corrupts only the protected bits, so the bench uses mask patterns that mix kept and passed bits in every slice.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  localparam int SEG_W  = 16;
  localparam int NSEG   = 4;
  localparam int WORD_W = SEG_W * NSEG;
  localparam int SIW    = $clog2(NSEG);

  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SIW-1:0]    seg_idx_t;

  typedef enum logic [1:0] {
    CYC_CMD_WR  = 2'b00,
    CYC_DATA_WR = 2'b01,
    CYC_CMD_RD  = 2'b10,
    CYC_DATA_RD = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    TGT_CMP   = 2'd0,
    TGT_MASK1 = 2'd1,
    TGT_MASK2 = 2'd2,
    TGT_ENTRY = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    WM_NONE  = 2'd0,
    WM_MASK1 = 2'd1,
    WM_MASK2 = 2'd2,
    WM_OFF   = 2'd3
  } wm_e;

  localparam logic [3:0] OP_SEL_DST  = 4'd1;
  localparam logic [3:0] OP_SEL_SRC  = 4'd2;
  localparam logic [3:0] OP_SET_SEG  = 4'd3;
  localparam logic [3:0] OP_CLR_SEG  = 4'd4;
  localparam logic [3:0] OP_ROT      = 4'd5;
  localparam logic [3:0] OP_SWAP     = 4'd6;
  localparam logic [3:0] OP_SET_ADDR = 4'd7;
endpackage

// File: rtl/seg_loader_ctr.sv
module seg_loader_ctr
  import seg_loader_pkg::*;
(
  input  seg_idx_t cur_i,
  input  seg_idx_t lo_i,
  input  seg_idx_t hi_i,
  output seg_idx_t nxt_o,
  output logic     term_o
);
  assign term_o = (cur_i == hi_i);
  assign nxt_o  = term_o ? lo_i : cur_i + seg_idx_t'(1);
endmodule

// File: rtl/seg_loader_merge.sv
module seg_loader_merge
  import seg_loader_pkg::*;
(
  input  word_t    word_i,
  input  seg_idx_t idx_i,
  input  seg_t     data_i,
  input  word_t    mask_i,
  output word_t    word_o
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    // mask bit 1 keeps the old bit
    assign word_o[g*SEG_W +: SEG_W] = (idx_i == seg_idx_t'(g))
      ? ((word_i[g*SEG_W +: SEG_W] & mask_i[g*SEG_W +: SEG_W]) |
         (data_i & ~mask_i[g*SEG_W +: SEG_W]))
      : word_i[g*SEG_W +: SEG_W];
  end
endmodule

// File: rtl/seg_loader_rot.sv
module seg_loader_rot #(
  parameter int W = 64
) (
  input  logic [W-1:0] word_i,
  input  logic         right_i,
  output logic [W-1:0] word_o
);
  assign word_o = right_i ? {word_i[0], word_i[W-1:1]}
                          : {word_i[W-2:0], word_i[W-1]};
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_loader_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              cm_ni,
  input  logic [SEG_W-1:0]  dq_i,
  output logic [SEG_W-1:0]  dq_o,
  output logic              dq_oe_o,
  output logic              cmp_req_o,
  output logic              match_clr_o,
  output logic [WORD_W-1:0] cmp_word_o,
  output logic [WORD_W-1:0] mask1_o,
  output logic [WORD_W-1:0] mask2_o
);
  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    tgt_e          dst;
    tgt_e          src;
    wm_e           wm;
    seg_idx_t      dst_lo, dst_hi, src_lo, src_hi;
    seg_idx_t      dst_ptr, src_ptr;
    logic [AW-1:0] addr;
    word_t         mask1;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    dst: TGT_CMP, src: TGT_CMP, wm: WM_NONE,
    dst_lo: '0, dst_hi: seg_idx_t'(NSEG-1),
    src_lo: '0, src_hi: seg_idx_t'(NSEG-1),
    dst_ptr: '0, src_ptr: '0, addr: '0, mask1: '0
  };

  logic  ce_q;
  cyc_e  cyc_q, cyc_cur;
  seg_t  din_q;
  logic  act_q;
  cfg_t  cfg_q [2];
  cfg_t  cur;
  word_t cmp_q, m2_q;
  word_t mem_q [ENTRIES];
  logic  req_q, clr_q;

  wire fall = ~ce_ni & ce_q;
  wire rise = ce_ni & ~ce_q;

  assign cyc_cur = fall ? cyc_e'({we_ni, cm_ni}) : cyc_q;
  assign cur     = cfg_q[act_q];

  // access framing: type latched at open, data sampled while open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q  <= 1'b1;
      cyc_q <= CYC_DATA_RD;
      din_q <= '0;
    end else begin
      ce_q <= ce_ni;
      if (fall)   cyc_q <= cyc_e'({we_ni, cm_ni});
      if (!ce_ni) din_q <= dq_i;
    end
  end

  // datapath pieces
  word_t    dst_old, src_word, wmask, dst_new, cmp_rot, m2_rot;
  seg_idx_t dst_nxt, src_nxt;
  logic     dst_term, src_term;

  always_comb begin
    unique case (cur.dst)
      TGT_CMP:   dst_old = cmp_q;
      TGT_MASK1: dst_old = cur.mask1;
      TGT_MASK2: dst_old = m2_q;
      default:   dst_old = mem_q[cur.addr];
    endcase
    unique case (cur.src)
      TGT_CMP:   src_word = cmp_q;
      TGT_MASK1: src_word = cur.mask1;
      TGT_MASK2: src_word = m2_q;
      default:   src_word = mem_q[cur.addr];
    endcase
    unique case (cur.wm)
      WM_MASK1: wmask = cur.mask1;
      WM_MASK2: wmask = m2_q;
      default:  wmask = '0;
    endcase
  end

  seg_loader_merge u_merge (
    .word_i(dst_old), .idx_i(cur.dst_ptr), .data_i(din_q),
    .mask_i(wmask), .word_o(dst_new)
  );

  seg_loader_ctr u_dst_ctr (
    .cur_i(cur.dst_ptr), .lo_i(cur.dst_lo), .hi_i(cur.dst_hi),
    .nxt_o(dst_nxt), .term_o(dst_term)
  );
  seg_loader_ctr u_src_ctr (
    .cur_i(cur.src_ptr), .lo_i(cur.src_lo), .hi_i(cur.src_hi),
    .nxt_o(src_nxt), .term_o(src_term)
  );

  seg_loader_rot #(.W(WORD_W)) u_rot_cmp (.word_i(cmp_q), .right_i(din_q[1]), .word_o(cmp_rot));
  seg_loader_rot #(.W(WORD_W)) u_rot_m2  (.word_i(m2_q),  .right_i(din_q[1]), .word_o(m2_rot));

  wire       cmd_wr  = rise && (cyc_q == CYC_CMD_WR) && (din_q[11:8] == 4'd0);
  wire       data_wr = rise && (cyc_q == CYC_DATA_WR);
  wire       data_rd = rise && (cyc_q == CYC_DATA_RD);
  wire [3:0] op      = din_q[15:12];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cfg_q[0] <= CFG_RST;
      cfg_q[1] <= CFG_RST;
      cmp_q <= '0;
      m2_q  <= '0;
      req_q <= 1'b0;
      clr_q <= 1'b0;
      for (int e = 0; e < ENTRIES; e++) mem_q[e] <= '0;
    end else begin
      req_q <= 1'b0;
      clr_q <= 1'b0;
      if (data_wr) begin
        unique case (cur.dst)
          TGT_CMP:   cmp_q <= dst_new;
          TGT_MASK1: cfg_q[act_q].mask1 <= dst_new;
          TGT_MASK2: m2_q <= dst_new;
          default:   mem_q[cur.addr] <= dst_new;
        endcase
        cfg_q[act_q].dst_ptr <= dst_nxt;
        req_q <= dst_term && (cur.dst != TGT_ENTRY);
      end
      if (data_rd) cfg_q[act_q].src_ptr <= src_nxt;
      if (cmd_wr) begin
        unique case (op)
          OP_SEL_DST: begin
            cfg_q[act_q].dst <= tgt_e'(din_q[1:0]);
            cfg_q[act_q].wm  <= wm_e'(din_q[3:2]);
          end
          OP_SEL_SRC: cfg_q[act_q].src <= tgt_e'(din_q[1:0]);
          OP_SET_SEG: begin
            cfg_q[act_q].dst_lo  <= din_q[0*SIW +: SIW];
            cfg_q[act_q].dst_hi  <= din_q[1*SIW +: SIW];
            cfg_q[act_q].src_lo  <= din_q[2*SIW +: SIW];
            cfg_q[act_q].src_hi  <= din_q[3*SIW +: SIW];
            cfg_q[act_q].dst_ptr <= din_q[0*SIW +: SIW];
            cfg_q[act_q].src_ptr <= din_q[2*SIW +: SIW];
          end
          OP_CLR_SEG: begin
            cfg_q[act_q].dst_lo  <= '0;
            cfg_q[act_q].dst_hi  <= seg_idx_t'(NSEG-1);
            cfg_q[act_q].src_lo  <= '0;
            cfg_q[act_q].src_hi  <= seg_idx_t'(NSEG-1);
            cfg_q[act_q].dst_ptr <= '0;
            cfg_q[act_q].src_ptr <= '0;
          end
          OP_ROT: begin
            if (din_q[0]) m2_q  <= m2_rot;
            else          cmp_q <= cmp_rot;
          end
          OP_SWAP: begin
            act_q <= ~act_q;
            clr_q <= 1'b1;
          end
          OP_SET_ADDR: cfg_q[act_q].addr <= din_q[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  wire  [SEG_W-1:0] status = {{(SEG_W-5){1'b0}}, act_q, cur.src_ptr, cur.dst_ptr};
  wire              rd_cyc = (cyc_cur == CYC_CMD_RD) || (cyc_cur == CYC_DATA_RD);

  assign dq_oe_o     = ~ce_ni & rd_cyc;
  assign dq_o        = !dq_oe_o ? '0 :
                       (cyc_cur == CYC_CMD_RD) ? status : src_word[cur.src_ptr*SEG_W +: SEG_W];
  assign cmp_req_o   = req_q;
  assign match_clr_o = clr_q;
  assign cmp_word_o  = cmp_q;
  assign mask1_o     = cur.mask1;
  assign mask2_o     = m2_q;

  logic unused_src_term;
  assign unused_src_term = src_term;
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_ni,
  input logic        dq_oe_o,
  input logic [15:0] dq_o,
  input logic        cmp_req_o,
  input logic        match_clr_o,
  input logic [63:0] cmp_word_o,
  input logic [63:0] mask1_o,
  input logic [63:0] mask2_o
);
  a_r3_bus_off_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !dq_oe_o && dq_o == 16'd0);

  a_r2_hold_while_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni |=> $stable(cmp_word_o) && $stable(mask1_o) && $stable(mask2_o));

  a_r2_hold_while_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni && $past(ce_ni) |=> $stable(cmp_word_o) && $stable(mask2_o));

  a_r6_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_o |=> !cmp_req_o);

  a_r6_req_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_o |-> $past(ce_ni) && !$past(ce_ni, 2));

  a_r9_clr_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_clr_o |-> $past(ce_ni) && !$past(ce_ni, 2) && !cmp_req_o);
endmodule

bind seg_loader seg_loader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .dq_oe_o(dq_oe_o), .dq_o(dq_o),
  .cmp_req_o(cmp_req_o), .match_clr_o(match_clr_o), .cmp_word_o(cmp_word_o),
  .mask1_o(mask1_o), .mask2_o(mask2_o)
);

// File: tb/test_seg_loader.sv
module test_seg_loader;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, cm_n = 1'b1;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic dq_oe, cmp_req, match_clr;
  logic [63:0] cmp_word, mask1, mask2;

  always #4 clk = ~clk;

  seg_loader i_seg_loader (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .cm_ni(cm_n),
    .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe), .cmp_req_o(cmp_req),
    .match_clr_o(match_clr), .cmp_word_o(cmp_word), .mask1_o(mask1), .mask2_o(mask2)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [63:0] r_cmp = '0, r_m2 = '0;
  logic [63:0] r_m1  [2] = '{64'd0, 64'd0};
  logic [63:0] r_mem [8];
  int act = 0;
  int dsel[2] = '{0, 0}, ssel[2] = '{0, 0}, wsel[2] = '{0, 0}, addr[2] = '{0, 0};
  int dlo[2] = '{0, 0}, dhi[2] = '{3, 3}, slo[2] = '{0, 0}, shi[2] = '{3, 3};
  int dp[2] = '{0, 0}, sp[2] = '{0, 0};

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [63:0] word_of(int t);
    case (t)
      0: return r_cmp;
      1: return r_m1[act];
      2: return r_m2;
      default: return r_mem[addr[act]];
    endcase
  endfunction

  // one bus access; flip inverts we_n after the access has opened
  task automatic bus(bit we, bit cm, logic [15:0] d, string tag, bit flip = 0);
    logic [15:0] exp_rd;
    bit exp_req, exp_clr;
    logic [63:0] w, mk, nw;
    logic [15:0] ms, os, ns;
    int sh, op;
    exp_rd = '0; exp_req = 0; exp_clr = 0;
    if (we && !cm) exp_rd = 16'({act[0], sp[act][1:0], dp[act][1:0]});
    if (we && cm)  exp_rd = 16'(word_of(ssel[act]) >> (16 * sp[act]));
    ce_n = 1'b0; we_n = we; cm_n = cm; dq_in = d;
    @(negedge clk);
    if (flip) begin we_n = ~we; #1; end
    chk(tag, "dq_oe (R3)", 64'(dq_oe), 64'(we));
    chk(tag, "dq_o", 64'(dq_out), 64'(exp_rd));
    ce_n = 1'b1;
    @(negedge clk);
    // reference commit
    if (!we && !cm && d[11:8] == 4'd0) begin
      op = int'(d[15:12]);
      case (op)
        1: begin dsel[act] = int'(d[1:0]); wsel[act] = int'(d[3:2]); end
        2: ssel[act] = int'(d[1:0]);
        3: begin
          dlo[act] = int'(d[1:0]); dhi[act] = int'(d[3:2]);
          slo[act] = int'(d[5:4]); shi[act] = int'(d[7:6]);
          dp[act] = dlo[act]; sp[act] = slo[act];
        end
        4: begin dlo[act] = 0; dhi[act] = 3; slo[act] = 0; shi[act] = 3; dp[act] = 0; sp[act] = 0; end
        5: begin
          if (d[0]) r_m2  = d[1] ? {r_m2[0], r_m2[63:1]}   : {r_m2[62:0], r_m2[63]};
          else      r_cmp = d[1] ? {r_cmp[0], r_cmp[63:1]} : {r_cmp[62:0], r_cmp[63]};
        end
        6: begin act = 1 - act; exp_clr = 1; end
        7: addr[act] = int'(d[2:0]);
        default: ;
      endcase
    end else if (!we && cm) begin
      w  = word_of(dsel[act]);
      mk = (wsel[act] == 1) ? r_m1[act] : (wsel[act] == 2) ? r_m2 : 64'd0;
      sh = 16 * dp[act];
      ms = 16'(mk >> sh); os = 16'(w >> sh);
      ns = (os & ms) | (d & ~ms);
      nw = (w & ~(64'hFFFF << sh)) | (64'(ns) << sh);
      case (dsel[act])
        0: r_cmp = nw;
        1: r_m1[act] = nw;
        2: r_m2 = nw;
        default: r_mem[addr[act]] = nw;
      endcase
      exp_req = (dp[act] == dhi[act]) && dsel[act] != 3;
      dp[act] = (dp[act] == dhi[act]) ? dlo[act] : (dp[act] + 1) % 4;
    end else if (we && cm) begin
      sp[act] = (sp[act] == shi[act]) ? slo[act] : (sp[act] + 1) % 4;
    end
    chk(tag, "cmp_req (R6)", 64'(cmp_req), 64'(exp_req));
    chk(tag, "match_clr (R9)", 64'(match_clr), 64'(exp_clr));
    chk(tag, "cmp_word", cmp_word, r_cmp);
    chk(tag, "mask1", mask1, r_m1[act]);
    chk(tag, "mask2", mask2, r_m2);
  endtask

  // every clock: idle bus must be released (R3)
  always @(posedge clk) begin
    #2;
    if (rst_n && ce_n) chk("R3", "idle dq_oe", 64'(dq_oe), 64'd0);
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (r_mem[e]) r_mem[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "cmp_word", cmp_word, 64'd0);
    chk("R13", "mask1", mask1, 64'd0);
    chk("R13", "mask2", mask2, 64'd0);
    chk("R13", "cmp_req", 64'(cmp_req), 64'd0);
    bus(1, 0, 16'h0000, "R13");

    // R1 / R4: four slices into the comparand, request on the last
    bus(0, 0, 16'h1000, "R4");
    bus(0, 1, 16'h1111, "R4");
    bus(0, 1, 16'h2222, "R4");
    bus(0, 1, 16'h3333, "R4");
    bus(0, 1, 16'h4444, "R6");
    bus(1, 0, 16'h0000, "R1");

    // R11: source counter walks and wraps
    bus(0, 0, 16'h2000, "R11");
    for (int i = 0; i < 5; i++) bus(1, 1, 16'h0000, "R11");
    bus(1, 0, 16'h0000, "R11");

    // R2: changing the selects mid-access has no effect
    bus(1, 0, 16'h0000, "R2", 1);
    bus(0, 0, 16'h3005, "R2", 1);
    bus(1, 0, 16'h0000, "R2");
    bus(0, 1, 16'h7777, "R2", 1);

    // R5: programmable limits, dst 1..2, src 0..3
    bus(0, 0, 16'h30C9, "R5");
    bus(0, 1, 16'hAAAA, "R5");
    bus(0, 1, 16'hBBBB, "R5");
    bus(0, 1, 16'hCCCC, "R5");
    bus(1, 0, 16'h0000, "R5");

    // R10: single-access clear
    bus(0, 0, 16'h4000, "R10");
    bus(1, 0, 16'h0000, "R10");

    // R6: mask two load, request at the end
    bus(0, 0, 16'h1002, "R6");
    bus(0, 1, 16'h00FF, "R6");
    bus(0, 1, 16'h0F0F, "R6");
    bus(0, 1, 16'hF0F0, "R6");
    bus(0, 1, 16'hFF00, "R6");

    // R7: comparand write through mask two
    bus(0, 0, 16'h1008, "R7");
    for (int i = 0; i < 4; i++) bus(0, 1, 16'h5A5A, "R7");

    // R8: rotations
    bus(0, 0, 16'h5000, "R8");
    bus(0, 0, 16'h5002, "R8");
    bus(0, 0, 16'h5002, "R8");
    bus(0, 0, 16'h5001, "R8");
    bus(0, 0, 16'h5003, "R8");
    bus(0, 0, 16'h5003, "R8");

    // R9: per-bank mask one and swap
    bus(0, 0, 16'h1001, "R9");
    bus(0, 1, 16'h1234, "R9");
    bus(0, 1, 16'h5678, "R9");
    bus(0, 0, 16'h6000, "R9");
    bus(1, 0, 16'h0000, "R9");
    bus(0, 0, 16'h1001, "R9");
    for (int i = 0; i < 4; i++) bus(0, 1, 16'hCAFE, "R9");
    bus(0, 0, 16'h6000, "R9");
    bus(1, 0, 16'h0000, "R9");
    bus(0, 1, 16'h9ABC, "R9");
    bus(0, 1, 16'hDEF0, "R9");

    // R12: table entries
    bus(0, 0, 16'h7003, "R12");
    bus(0, 0, 16'h1003, "R12");
    bus(0, 1, 16'h0101, "R12");
    bus(0, 1, 16'h0202, "R12");
    bus(0, 1, 16'h0303, "R12");
    bus(0, 1, 16'h0404, "R12");
    bus(0, 0, 16'h2003, "R12");
    for (int i = 0; i < 4; i++) bus(1, 1, 16'h0000, "R12");
    bus(0, 0, 16'h7005, "R12");
    bus(1, 1, 16'h0000, "R12");
    bus(0, 0, 16'h7003, "R12");

    // R7: table write through mask one
    bus(0, 0, 16'h1007, "R7");
    for (int i = 0; i < 4; i++) bus(0, 1, 16'hFFFF, "R7");
    for (int i = 0; i < 4; i++) bus(1, 1, 16'h0000, "R7");

    // R1: reserved command bits set -> ignored
    bus(0, 0, 16'h7100, "R1");
    bus(0, 0, 16'h5800, "R1");
    bus(1, 1, 16'h0000, "R1");

    // R11: read masks back
    bus(0, 0, 16'h2002, "R11");
    for (int i = 0; i < 4; i++) bus(1, 1, 16'h0000, "R11");
    bus(0, 0, 16'h2001, "R11");
    for (int i = 0; i < 4; i++) bus(1, 1, 16'h0000, "R11");

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule